// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one whole I2C master transaction from a single command word. The command holds a start request, a 7-bit target address, a read/write direction, an 8-bit payload count and an end-mode selection. Once the command is taken, the sequencer requests a START from a bit-level engine, sends the address byte, and checks the acknowledge. It then moves the requested number of payload bytes. Write bytes come in on a valid/ready transmit stream. Read bytes go out on a valid/ready receive stream. Up to 255 bytes move without any further command.

At the end of the payload, the end-mode selection decides what happens next. In automatic mode, the sequencer requests STOP by itself. In software mode, it parks with the clock held low and raises a completion flag. It then waits for a new command, which is either a repeated START carrying fresh fields or a STOP request. A negative acknowledge on the address, or on a written byte, always ends the transfer with STOP and sets a sticky flag. The bit-level engine is outside this block and is driven through single-cycle requests. Each request is answered by one completion pulse.

Back-pressure on the streams works as follows. A transmit byte is taken only in a cycle where both `tx_valid` and `tx_ready` are high. While no byte is offered, the transfer waits. A received byte stays on `rx_data` with `rx_valid` high until `rx_ready` accepts it. No further read is requested while that byte is still waiting.

Top module: `i2cm_seq`

## Requirements
- R1: After reset, `busy`, `xfer_done`, `nack_flag`, `bus_hold`, `eng_go`, `tx_ready` and `rx_valid` are all low.
- R2: When idle, a command with `cmd_start` high produces a START request (`eng_op`=0). After that request completes, the sequencer requests a byte write (`eng_op`=2) of `{cmd_addr, cmd_read}`, where `cmd_read`=1 means read.
- R3: In a write transfer, the payload bytes are taken from the transmit stream in order. Each byte is sent as one byte-write request after the previous byte was acknowledged (`eng_ack_n`=0).
- R4: While a write transfer waits for transmit data and `tx_valid` is low, no engine request is issued and `bus_hold` is high.
- R5: In a read transfer, one byte-read request (`eng_op`=3) is issued per payload byte. `eng_nack` is 0 on every request except the final one, where it is 1. The received bytes appear on the receive stream in order.
- R6: While `rx_valid` is high and `rx_ready` is low, `rx_data` is stable and no new read request is issued.
- R7: In automatic end mode (`cmd_auto_end`=1), a STOP request (`eng_op`=1) follows completion of the last byte.
- R8: In software end mode, after the last byte, `xfer_done` and `bus_hold` go high and `busy` stays high. No engine request is issued until the next command.
- R9: While `xfer_done` is high, a start command issues a repeated START using the new fields, and a command with only `cmd_stop` high issues STOP.
- R10: `eng_ack_n`=1 on the address byte or on a written byte sets `nack_flag` and issues STOP in either end mode. No further payload byte moves. `nack_flag` clears when the next start command is accepted.
- R11: A count of zero sends only START and the address byte, followed by the selected end action.
- R12: A start command that arrives while `busy` is high and `xfer_done` is low is ignored. The transfer in progress keeps its own fields.
- R13: `busy` rises with the START request and falls only when the STOP request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_start | input | 1 | Command requests a (repeated) START |
| cmd_stop | input | 1 | Command requests STOP (used while parked) |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | Direction, 1 = read |
| cmd_count | input | 8 | Payload byte count |
| cmd_auto_end | input | 1 | 1 = automatic STOP, 0 = park and wait |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken this cycle if valid |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer accepts received byte |
| rx_data | output | 8 | Received byte |
| eng_go | output | 1 | One-cycle request to the bit engine |
| eng_op | output | 2 | Request kind: 0 START, 1 STOP, 2 write byte, 3 read byte |
| eng_wdata | output | 8 | Byte to write |
| eng_nack | output | 1 | Acknowledge bit to send after a read byte, 1 = NACK |
| eng_done | input | 1 | Engine completion pulse |
| eng_ack_n | input | 1 | Acknowledge seen after a written byte, 1 = NACK |
| eng_rdata | input | 8 | Byte read by the engine |
| busy | output | 1 | Transaction in progress |
| xfer_done | output | 1 | Parked after last byte in software end mode |
| nack_flag | output | 1 | Sticky negative-acknowledge flag |
| bus_hold | output | 1 | Clock held low while waiting |

## Verification
The assertions assume that the engine answers each request with exactly one `eng_done` pulse, arriving at least one cycle after `eng_go`. They also assume that `eng_ack_n` and `eng_rdata` are meaningful in that pulse's cycle, and that the command fields are valid in the strobe cycle. The bench keeps to these rules with a model engine that records every request and pulses completion after a fixed delay, with scripted acknowledges and read data. The bench starts new commands only when the block is idle or parked. The one exception is the deliberate busy-time command that R12 calls for.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WR    = 2'd2,
    OP_RD    = 2'd3
  } eng_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_W,
    ST_ADDR_W,
    ST_TX,
    ST_WR_W,
    ST_RXQ,
    ST_RD_W,
    ST_TC,
    ST_STOP_W
  } seq_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              auto_end;
  } cmd_t;
endpackage

// File: rtl/i2cm_cmd_reg.sv
module i2cm_cmd_reg
  import i2cm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cmd_t cmd_in,
  output cmd_t cmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (load) cmd_q <= cmd_in;
  end
endmodule

// File: rtl/i2cm_byte_cnt.sv
module i2cm_byte_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec) cnt_q <= cnt_q - ONE;
  end

  assign zero = (cnt_q == '0);
  assign last = (cnt_q == ONE);

  // payload moves never outrun the requested count
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
endmodule

// File: rtl/i2cm_rx_slot.sv
module i2cm_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         rx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (load) begin
      rx_valid <= 1'b1;
      rx_data  <= din;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assign full = rx_valid && !rx_ready;

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  cmd_t              cur,
  input  logic              cnt_zero,
  input  logic              cnt_last,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              slot_full,
  input  logic              eng_done,
  input  logic              eng_ack_n,
  output logic              cmd_load,
  output logic              cnt_dec,
  output logic              slot_load,
  output logic              tx_ready,
  output logic              eng_go,
  output eng_op_e           eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nack,
  output logic              busy,
  output logic              xfer_done,
  output logic              nack_flag,
  output logic              bus_hold
);
  seq_st_e st, nxt;
  logic              go_n, nk_n, set_nack, end_act;
  eng_op_e           op_n;
  logic [BYTE_W-1:0] wd_n;

  always_comb begin
    nxt       = st;
    go_n      = 1'b0;
    op_n      = OP_START;
    wd_n      = eng_wdata;
    nk_n      = 1'b0;
    cmd_load  = 1'b0;
    cnt_dec   = 1'b0;
    slot_load = 1'b0;
    set_nack  = 1'b0;
    end_act   = 1'b0;
    case (st)
      ST_IDLE: if (cmd_valid && cmd_start) begin
        cmd_load = 1'b1; go_n = 1'b1; op_n = OP_START; nxt = ST_START_W;
      end
      ST_START_W: if (eng_done) begin
        go_n = 1'b1; op_n = OP_WR; wd_n = {cur.addr, cur.rd}; nxt = ST_ADDR_W;
      end
      ST_ADDR_W: if (eng_done) begin
        if (eng_ack_n) begin
          set_nack = 1'b1; go_n = 1'b1; op_n = OP_STOP; nxt = ST_STOP_W;
        end else if (cnt_zero) end_act = 1'b1;
        else if (cur.rd) nxt = ST_RXQ;
        else nxt = ST_TX;
      end
      ST_TX: if (tx_valid) begin
        go_n = 1'b1; op_n = OP_WR; wd_n = tx_data; cnt_dec = 1'b1; nxt = ST_WR_W;
      end
      ST_WR_W: if (eng_done) begin
        if (eng_ack_n) begin
          set_nack = 1'b1; go_n = 1'b1; op_n = OP_STOP; nxt = ST_STOP_W;
        end else if (cnt_zero) end_act = 1'b1;
        else nxt = ST_TX;
      end
      ST_RXQ: if (!slot_full) begin
        go_n = 1'b1; op_n = OP_RD; nk_n = cnt_last; cnt_dec = 1'b1; nxt = ST_RD_W;
      end
      ST_RD_W: if (eng_done) begin
        slot_load = 1'b1;
        if (cnt_zero) end_act = 1'b1;
        else nxt = ST_RXQ;
      end
      ST_TC: if (cmd_valid) begin
        if (cmd_start) begin
          cmd_load = 1'b1; go_n = 1'b1; op_n = OP_START; nxt = ST_START_W;
        end else if (cmd_stop) begin
          go_n = 1'b1; op_n = OP_STOP; nxt = ST_STOP_W;
        end
      end
      ST_STOP_W: if (eng_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (end_act) begin
      if (cur.auto_end) begin
        go_n = 1'b1; op_n = OP_STOP; nxt = ST_STOP_W;
      end else begin
        nxt = ST_TC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      eng_go    <= 1'b0;
      eng_op    <= OP_START;
      eng_wdata <= '0;
      eng_nack  <= 1'b0;
      nack_flag <= 1'b0;
    end else begin
      st     <= nxt;
      eng_go <= go_n;
      if (go_n) begin
        eng_op    <= op_n;
        eng_wdata <= wd_n;
        eng_nack  <= nk_n;
      end
      if (cmd_load) nack_flag <= 1'b0;
      else if (set_nack) nack_flag <= 1'b1;
    end
  end

  assign tx_ready  = (st == ST_TX);
  assign busy      = (st != ST_IDLE);
  assign xfer_done = (st == ST_TC);
  assign bus_hold  = (st == ST_TX) || (st == ST_RXQ) || (st == ST_TC);

  assert_tx_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> eng_go && eng_op == OP_WR && eng_wdata == $past(tx_data));
  assert_tx_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !tx_valid |=> !eng_go);
  assert_park_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !cmd_valid |=> !eng_go);
  assert_nack_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_flag) |-> eng_go && eng_op == OP_STOP);
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done && cmd_valid && cmd_start |=> !(eng_go && eng_op == OP_START));
  assert_go_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);
  assert_busy_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_read,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_auto_end,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              eng_go,
  output logic [1:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nack,
  input  logic              eng_done,
  input  logic              eng_ack_n,
  input  logic [BYTE_W-1:0] eng_rdata,
  output logic              busy,
  output logic              xfer_done,
  output logic              nack_flag,
  output logic              bus_hold
);
  cmd_t    cmd_in, cur;
  logic    cmd_load, cnt_dec, slot_load, slot_full, cnt_zero, cnt_last;
  eng_op_e op_int;

  assign cmd_in = '{addr: cmd_addr, rd: cmd_read, auto_end: cmd_auto_end};
  assign eng_op = op_int;

  i2cm_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .load(cmd_load), .cmd_in(cmd_in), .cmd_q(cur)
  );

  i2cm_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cmd_load), .load_val(cmd_count),
    .dec(cnt_dec), .zero(cnt_zero), .last(cnt_last)
  );

  i2cm_rx_slot #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(slot_load), .din(eng_rdata),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .full(slot_full)
  );

  i2cm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cur(cur), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .tx_valid(tx_valid), .tx_data(tx_data), .slot_full(slot_full),
    .eng_done(eng_done), .eng_ack_n(eng_ack_n),
    .cmd_load(cmd_load), .cnt_dec(cnt_dec), .slot_load(slot_load),
    .tx_ready(tx_ready), .eng_go(eng_go), .eng_op(op_int),
    .eng_wdata(eng_wdata), .eng_nack(eng_nack),
    .busy(busy), .xfer_done(xfer_done), .nack_flag(nack_flag), .bus_hold(bus_hold)
  );

  // R7: after STOP request in auto mode, the engine is not asked anything else until idle
  assert_stop_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go && eng_op == 2'd1 |=> !eng_go);
endmodule

// File: tb/i2cm_seq_tb.sv
module i2cm_seq_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 0, cmd_start = 0, cmd_stop = 0, cmd_read = 0, cmd_auto_end = 0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_count = '0;
  logic       tx_valid, tx_ready, rx_valid, rx_ready = 0;
  logic [7:0] tx_data, rx_data;
  logic       eng_go, eng_nack, eng_done = 0, eng_ack_n = 0;
  logic [1:0] eng_op;
  logic [7:0] eng_wdata, eng_rdata = '0;
  logic       busy, xfer_done, nack_flag, bus_hold;

  int total = 0, bad = 0, cyc = 0;
  localparam int DLY = 3;

  // engine model log
  int        log_n = 0, wr_idx = 0, rd_idx = 0, nack_at = -1, pend = 0;
  logic [1:0] log_op [64];
  logic [7:0] log_dat[64];
  logic       log_nk [64];

  // transmit feeder and receive sink
  logic [7:0] tx_mem[16];
  int         tx_idx = 0, tx_len = 0, rx_n = 0;
  logic       tx_en = 0;
  logic [7:0] rx_log[16];

  always #5 clk = ~clk;

  i2cm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .cmd_count(cmd_count), .cmd_auto_end(cmd_auto_end),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_go(eng_go), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_ack_n(eng_ack_n), .eng_rdata(eng_rdata),
    .busy(busy), .xfer_done(xfer_done), .nack_flag(nack_flag), .bus_hold(bus_hold)
  );

  assign tx_valid = tx_en && (tx_idx < tx_len);
  assign tx_data  = tx_mem[tx_idx[3:0]];

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    if (rx_valid && rx_ready) begin
      rx_log[rx_n[3:0]] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  always @(negedge clk) begin
    eng_done = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) eng_done = 1'b1;
    end
    if (eng_go) begin
      log_op[log_n[5:0]]  = eng_op;
      log_dat[log_n[5:0]] = eng_wdata;
      log_nk[log_n[5:0]]  = eng_nack;
      log_n = log_n + 1;
      pend = DLY;
      if (eng_op == 2'd2) begin
        eng_ack_n = (wr_idx == nack_at);
        wr_idx = wr_idx + 1;
      end else begin
        eng_ack_n = 1'b0;
      end
      if (eng_op == 2'd3) begin
        eng_rdata = 8'hA0 + 8'(rd_idx);
        rd_idx = rd_idx + 1;
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL R13 watchdog act=hung exp=finished");
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic exp_op(string req, int i, int op, int dat, int nk);
    chk({req, " op"}, int'(log_op[i]), op);
    if (dat >= 0) chk({req, " data"}, int'(log_dat[i]), dat);
    if (nk >= 0) chk({req, " nack"}, int'(log_nk[i]), nk);
  endtask

  task automatic cyc_wait(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr(int nk);
    log_n = 0; wr_idx = 0; rd_idx = 0; nack_at = nk;
    tx_idx = 0; rx_n = 0; tx_en = 0;
  endtask

  task automatic send_cmd(bit st, bit sp, logic [6:0] a, bit rd, logic [7:0] n, bit au);
    @(negedge clk);
    cmd_valid = 1; cmd_start = st; cmd_stop = sp; cmd_addr = a;
    cmd_read = rd; cmd_count = n; cmd_auto_end = au;
    @(negedge clk);
    cmd_valid = 0; cmd_start = 0; cmd_stop = 0;
  endtask

  task automatic wait_idle(string req);
    int k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk({req, " idle reached"}, int'(busy), 0);
    // R13: busy falls only after the STOP request has been issued
    chk("R13 last op before idle is STOP", int'(log_op[(log_n - 1) & 63]), 1);
  endtask

  task automatic wait_tc();
    int k = 0;
    while (!xfer_done && k < 2000) begin @(negedge clk); k++; end
    chk("R8 parked", int'(xfer_done), 1);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 xfer_done", int'(xfer_done), 0);
    chk("R1 nack_flag", int'(nack_flag), 0);
    chk("R1 bus_hold", int'(bus_hold), 0);
    chk("R1 eng_go", int'(eng_go), 0);
    chk("R1 tx_ready", int'(tx_ready), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
  endtask

  task automatic t_write_auto();
    clr(-1);
    tx_mem[0] = 8'h11; tx_mem[1] = 8'h22; tx_mem[2] = 8'h33; tx_len = 3; tx_en = 1;
    send_cmd(1, 0, 7'h50, 0, 8'd3, 1);
    chk("R13 busy after start", int'(busy), 1);
    wait_idle("R7");
    chk("R3 request count", log_n, 6);
    exp_op("R2 start", 0, 0, -1, -1);
    exp_op("R2 addr write", 1, 2, 8'hA0, -1);
    exp_op("R3 byte0", 2, 2, 8'h11, -1);
    exp_op("R3 byte1", 3, 2, 8'h22, -1);
    exp_op("R3 byte2", 4, 2, 8'h33, -1);
    exp_op("R7 stop", 5, 1, -1, -1);
    chk("R3 bytes consumed", tx_idx, 3);
  endtask

  task automatic t_tx_stall();
    clr(-1);
    tx_mem[0] = 8'h5A; tx_len = 1; tx_en = 0;
    send_cmd(1, 0, 7'h33, 0, 8'd1, 1);
    cyc_wait(30);
    chk("R4 no request while stalled", log_n, 2);
    chk("R4 bus_hold", int'(bus_hold), 1);
    chk("R4 tx_ready offered", int'(tx_ready), 1);
    tx_en = 1;
    wait_idle("R4");
    chk("R4 resume count", log_n, 4);
    exp_op("R4 byte", 2, 2, 8'h5A, -1);
  endtask

  task automatic t_read_auto();
    clr(-1);
    rx_ready = 0;
    send_cmd(1, 0, 7'h21, 1, 8'd3, 1);
    cyc_wait(40);
    chk("R6 rx_valid held", int'(rx_valid), 1);
    chk("R6 rx_data first", int'(rx_data), 8'hA0);
    chk("R6 no read while full", log_n, 3);
    cyc_wait(10);
    chk("R6 rx_data stable", int'(rx_data), 8'hA0);
    @(negedge clk); rx_ready = 1;
    wait_idle("R5");
    cyc_wait(2);
    rx_ready = 0;
    exp_op("R2 read addr", 1, 2, 8'h43, -1);
    exp_op("R5 read0", 2, 3, -1, 0);
    exp_op("R5 read1", 3, 3, -1, 0);
    exp_op("R5 read2 last", 4, 3, -1, 1);
    exp_op("R7 stop after read", 5, 1, -1, -1);
    chk("R5 rx count", rx_n, 3);
    chk("R5 rx0", int'(rx_log[0]), 8'hA0);
    chk("R5 rx1", int'(rx_log[1]), 8'hA1);
    chk("R5 rx2", int'(rx_log[2]), 8'hA2);
  endtask

  task automatic t_sw_end();
    clr(-1);
    tx_mem[0] = 8'hC1; tx_mem[1] = 8'hC2; tx_len = 2; tx_en = 1;
    send_cmd(1, 0, 7'h12, 0, 8'd2, 0);
    wait_tc();
    chk("R8 busy while parked", int'(busy), 1);
    chk("R8 bus_hold while parked", int'(bus_hold), 1);
    cyc_wait(20);
    chk("R8 no request while parked", log_n, 4);
    rx_ready = 1;
    send_cmd(1, 0, 7'h21, 1, 8'd1, 0);
    wait_tc();
    exp_op("R9 repeated start", 4, 0, -1, -1);
    exp_op("R9 new addr", 5, 2, 8'h43, -1);
    exp_op("R9 single read nack", 6, 3, -1, 1);
    chk("R9 rx byte", int'(rx_log[0]), 8'hA0);
    send_cmd(1, 0, 7'h05, 0, 8'd0, 0);
    wait_tc();
    chk("R11 zero count requests", log_n, 9);
    exp_op("R11 addr only", 8, 2, 8'h0A, -1);
    send_cmd(0, 1, 7'h00, 0, 8'd0, 0);
    wait_idle("R9");
    exp_op("R9 stop command", 9, 1, -1, -1);
    rx_ready = 0;
  endtask

  task automatic t_nack();
    clr(0);
    tx_mem[0] = 8'h77; tx_mem[1] = 8'h78; tx_len = 2; tx_en = 1;
    send_cmd(1, 0, 7'h40, 0, 8'd2, 0);
    wait_idle("R10");
    chk("R10 addr nack flag", int'(nack_flag), 1);
    chk("R10 addr nack requests", log_n, 3);
    exp_op("R10 stop after addr nack", 2, 1, -1, -1);
    chk("R10 no byte taken", tx_idx, 0);
    clr(2);
    tx_mem[0] = 8'h91; tx_mem[1] = 8'h92; tx_mem[2] = 8'h93; tx_len = 3; tx_en = 1;
    send_cmd(1, 0, 7'h41, 0, 8'd3, 1);
    chk("R10 flag cleared by start", int'(nack_flag), 0);
    wait_idle("R10");
    chk("R10 data nack flag", int'(nack_flag), 1);
    chk("R10 data nack requests", log_n, 5);
    exp_op("R10 stop after data nack", 4, 1, -1, -1);
    chk("R10 bytes taken", tx_idx, 2);
  endtask

  task automatic t_busy_ignore();
    clr(-1);
    tx_mem[0] = 8'hE1; tx_mem[1] = 8'hE2; tx_len = 2; tx_en = 0;
    send_cmd(1, 0, 7'h11, 0, 8'd2, 1);
    cyc_wait(20);
    chk("R12 stalled count", log_n, 2);
    send_cmd(1, 0, 7'h7F, 1, 8'd5, 0);
    cyc_wait(20);
    chk("R12 start ignored", log_n, 2);
    tx_en = 1;
    wait_idle("R12");
    chk("R12 original length kept", log_n, 5);
    exp_op("R12 original addr", 1, 2, 8'h22, -1);
    exp_op("R12 original byte", 3, 2, 8'hE2, -1);
  endtask

  initial begin
    cyc_wait(3);
    t_reset();
    rst_n = 1;
    cyc_wait(2);
    t_reset();
    t_write_auto();
    t_tx_stall();
    t_read_auto();
    t_sw_end();
    t_nack();
    t_busy_ignore();
    cyc_wait(5);
    finish_run();
  end
endmodule